// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Block

This block holds the two byte-wide registers through which software steers a small Ethernet MAC and watches its state. A control register at address 0x0 selects the PHY, enables wakeup detection, forces collisions for test, sets duplex and picks a loopback mode. It also starts a self-timed soft reset. A status register at address 0x1 combines live levels from the MAC and PHY with three sticky event flags. These flags can be cleared in two ways: by reading the status register, or by writing a one to the flag.

Access is through a plain synchronous register bus. There is an address, a write strobe with write data, and a read strobe. Read data is combinational and valid in the same cycle as the read strobe. It shows the values held before any clear-on-read takes effect. Every transfer completes in one cycle, so the bus has no back-pressure. The status and control pins are plain levels or one-cycle pulses, with no handshake.

Top module: `netmac_csr`

## Requirements
- R1: After reset, every control output is 0, the soft reset is idle, all three event flags are 0, and the control register reads 0 while `phy_fdx_i` is 0.
- R2: A write to address 0x0 stores the following fields: bit 7 selects the external PHY, bit 6 enables wakeup, bit 4 forces collision, and bits 2:1 set the loopback mode (00 none, 01 MAC loopback, 10 PHY digital, 11 PHY analog). Reading address 0x0 returns these fields in the same positions, and bit 5 always reads 0.
- R3: While the stored PHY select (bit 7) is 0, `fdx_o` and control bit 3 follow `phy_fdx_i`, and a write to bit 3 has no effect. While the stored select is 1, bit 3 is stored by writes and drives `fdx_o`. The select value held before the write decides which case applies.
- R4: Writing 1 to control bit 0 while no soft reset is running asserts `soft_rst_o`, and control bit 0 reads 1. Both begin in the next cycle and last exactly CLK_HZ/100000 cycles (10 µs), then clear by themselves.
- R5: While a soft reset runs, force collision, the stored duplex, the loopback mode and both TX-done flags are held at 0. A TX-done pulse in that time is lost, and a further bit-0 write does not restart the timer. The PHY select, the wakeup enable and the wakeup flag keep their values.
- R6: Status bits are as follows. Bit 7 is `phy_speed10_i` and bit 6 is `phy_link_i`. Bit 5 is the wakeup flag. Bit 4 is 1 when `tx_count_i` is 2 or more. Bit 3 is the packet-2 done flag and bit 2 is the packet-1 done flag. Bit 1 is `rx_overflow_i` and bit 0 is `rx_ready_i`.
- R7: A one-cycle pulse sets an event flag, and the flag holds. `tx_done_i[0]` sets bit 2 and `tx_done_i[1]` sets bit 3. `wake_event_i` sets bit 5 only while wakeup is enabled.
- R8: A read of address 0x1 returns the flags as they were, and then clears all three flags.
- R9: A write to address 0x1 clears each flag whose bit (5, 3 or 2) is written as 1. Flags written as 0, and all other bits, are unaffected.
- R10: If a flag's event pulse arrives in the same cycle as a read-clear or a write-one-clear, the flag ends up set.
- R11: A control write with bit 6 at 0 clears the wakeup flag.
- R12: Reads of any other address return 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | ADDR_W | register address |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 8 | write data |
| bus_rd | input | 1 | read strobe |
| bus_rdata | output | 8 | read data, valid while bus_rd is high |
| phy_link_i | input | 1 | PHY link up |
| phy_speed10_i | input | 1 | PHY at 10 Mb/s (0 = 100 Mb/s) |
| phy_fdx_i | input | 1 | duplex reported by internal PHY |
| wake_event_i | input | 1 | wakeup event pulse |
| tx_done_i | input | 2 | transmit done pulses, one per packet slot |
| tx_count_i | input | TXCNT_W | packets held in transmit memory |
| rx_overflow_i | input | 1 | receive overflow level |
| rx_ready_i | input | 1 | receive packet waiting level |
| ext_phy_sel_o | output | 1 | external PHY selected |
| wake_en_o | output | 1 | wakeup detection enabled |
| force_col_o | output | 1 | force collision |
| fdx_o | output | 1 | effective full duplex |
| loop_mode_o | output | 2 | loopback mode |
| soft_rst_o | output | 1 | soft reset, high for the whole interval |

## Verification
A wrong flag state shows up in bits 5, 3 or 2 on the first status read. An event or clear that is lost or doubled is therefore caught within two cycles. A wrong decision on duplex writability shows at once on `fdx_o` and in control bit 3. A soft-reset timer that counts wrongly changes the length of the `soft_rst_o` pulse, which the bench measures to the exact cycle. Fields that soft reset should preserve are checked by reading the control register while the reset is still running.

// File: rtl/netmac_csr_pkg.sv
package netmac_csr_pkg;
  localparam int unsigned CSR_CTL_ADDR  = 0;
  localparam int unsigned CSR_STAT_ADDR = 1;

  // control bit positions
  localparam int unsigned CTL_EXT   = 7;
  localparam int unsigned CTL_WAKE  = 6;
  localparam int unsigned CTL_FCOL  = 4;
  localparam int unsigned CTL_FDX   = 3;
  localparam int unsigned CTL_RST   = 0;

  // status bit positions of the sticky flags
  localparam int unsigned ST_WAKE = 5;
  localparam int unsigned ST_TX2  = 3;
  localparam int unsigned ST_TX1  = 2;

  localparam int unsigned NFLAG = 3;
  localparam int unsigned FLG_WAKE = 0;
  localparam int unsigned FLG_TX1  = 1;
  localparam int unsigned FLG_TX2  = 2;

  typedef enum logic [1:0] {
    LB_NONE    = 2'b00,
    LB_MAC     = 2'b01,
    LB_PHY_DIG = 2'b10,
    LB_PHY_ANA = 2'b11
  } loop_mode_t;
endpackage

// File: rtl/netmac_srst_timer.sv
module netmac_srst_timer #(
  parameter int unsigned CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end
  end

  assign busy_o = busy_q;

  assert_srst_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q);
  assert_srst_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0) |=> !busy_q);
  assert_srst_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/netmac_evt_flag.sv
module netmac_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/netmac_csr.sv
module netmac_csr
  import netmac_csr_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned TXCNT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  input  logic               phy_link_i,
  input  logic               phy_speed10_i,
  input  logic               phy_fdx_i,
  input  logic               wake_event_i,
  input  logic [1:0]         tx_done_i,
  input  logic [TXCNT_W-1:0] tx_count_i,
  input  logic               rx_overflow_i,
  input  logic               rx_ready_i,
  output logic               ext_phy_sel_o,
  output logic               wake_en_o,
  output logic               force_col_o,
  output logic               fdx_o,
  output logic [1:0]         loop_mode_o,
  output logic               soft_rst_o
);
  localparam int unsigned SRST_RAW    = CLK_HZ / 100_000;
  localparam int unsigned SRST_CYCLES = (SRST_RAW < 1) ? 1 : SRST_RAW;

  logic ctl_hit, st_hit, ctl_wr, st_wr, st_rd;
  logic srst_start, srst_busy, srst_hold, wake_dis;
  logic ext_q, wake_en_q, fcol_q, fdx_q, fdx_eff;
  loop_mode_t lbk_q;
  logic [NFLAG-1:0] flg_set, flg_clr, flg_q;
  logic [7:0] ctl_word, st_word;
  logic tx_full;

  assign ctl_hit = (bus_addr == ADDR_W'(CSR_CTL_ADDR));
  assign st_hit  = (bus_addr == ADDR_W'(CSR_STAT_ADDR));
  assign ctl_wr  = bus_wr & ctl_hit;
  assign st_wr   = bus_wr & st_hit;
  assign st_rd   = bus_rd & st_hit;

  assign srst_start = ctl_wr & bus_wdata[CTL_RST] & ~srst_busy;
  assign srst_hold  = srst_start | srst_busy;
  assign wake_dis   = ctl_wr & ~bus_wdata[CTL_WAKE];

  netmac_srst_timer #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(srst_start),
    .busy_o (srst_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q     <= 1'b0;
      wake_en_q <= 1'b0;
      fcol_q    <= 1'b0;
      fdx_q     <= 1'b0;
      lbk_q     <= LB_NONE;
    end else begin
      if (ctl_wr) begin
        ext_q     <= bus_wdata[CTL_EXT];
        wake_en_q <= bus_wdata[CTL_WAKE];
      end
      if (srst_hold) begin
        fcol_q <= 1'b0;
        fdx_q  <= 1'b0;
        lbk_q  <= LB_NONE;
      end else if (ctl_wr) begin
        fcol_q <= bus_wdata[CTL_FCOL];
        if (ext_q) fdx_q <= bus_wdata[CTL_FDX];
        lbk_q  <= loop_mode_t'(bus_wdata[2:1]);
      end
    end
  end

  assign fdx_eff = ext_q ? fdx_q : phy_fdx_i;

  // sticky event flags: set has priority over clear
  always_comb begin
    flg_set[FLG_WAKE] = wake_event_i & wake_en_q & ~wake_dis;
    flg_clr[FLG_WAKE] = st_rd | (st_wr & bus_wdata[ST_WAKE]) | wake_dis;
    flg_set[FLG_TX1]  = tx_done_i[0] & ~srst_hold;
    flg_clr[FLG_TX1]  = st_rd | (st_wr & bus_wdata[ST_TX1]) | srst_hold;
    flg_set[FLG_TX2]  = tx_done_i[1] & ~srst_hold;
    flg_clr[FLG_TX2]  = st_rd | (st_wr & bus_wdata[ST_TX2]) | srst_hold;
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    netmac_evt_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flg_set[k]),
      .clr_i (flg_clr[k]),
      .flag_o(flg_q[k])
    );
  end

  assign tx_full = (tx_count_i >= TXCNT_W'(2));

  assign ctl_word = {ext_q, wake_en_q, 1'b0, fcol_q, fdx_eff, lbk_q, srst_busy};
  assign st_word  = {phy_speed10_i, phy_link_i, flg_q[FLG_WAKE], tx_full,
                     flg_q[FLG_TX2], flg_q[FLG_TX1], rx_overflow_i, rx_ready_i};

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (ctl_hit)     bus_rdata = ctl_word;
      else if (st_hit) bus_rdata = st_word;
    end
  end

  assign ext_phy_sel_o = ext_q;
  assign wake_en_o     = wake_en_q;
  assign force_col_o   = fcol_q;
  assign fdx_o         = fdx_eff;
  assign loop_mode_o   = lbk_q;
  assign soft_rst_o    = srst_busy;

  assert_wake_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_dis |=> !flg_q[FLG_WAKE]);
  assert_srst_holds_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (loop_mode_o == 2'b00 && !force_col_o && flg_q[FLG_TX1] == 1'b0
                    && flg_q[FLG_TX2] == 1'b0));
  assert_srst_keeps_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && !ctl_wr) |=> $stable(ext_q) && $stable(wake_en_q));
  assert_internal_fdx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_q && ctl_wr) |=> $stable(fdx_q));
endmodule

// File: tb/netmac_csr_tb_top.sv
`timescale 1ns/1ps
module netmac_csr_tb_top;
  localparam int unsigned CLK_HZ = 125_000_000;
  localparam int unsigned NSRST  = CLK_HZ / 100_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic phy_link_i = 0, phy_speed10_i = 0, phy_fdx_i = 0, wake_event_i = 0;
  logic [1:0] tx_done_i = '0, tx_count_i = '0;
  logic rx_overflow_i = 0, rx_ready_i = 0;
  logic ext_phy_sel_o, wake_en_o, force_col_o, fdx_o, soft_rst_o;
  logic [1:0] loop_mode_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  netmac_csr #(.CLK_HZ(CLK_HZ), .ADDR_W(4), .TXCNT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .phy_link_i(phy_link_i), .phy_speed10_i(phy_speed10_i), .phy_fdx_i(phy_fdx_i),
    .wake_event_i(wake_event_i), .tx_done_i(tx_done_i), .tx_count_i(tx_count_i),
    .rx_overflow_i(rx_overflow_i), .rx_ready_i(rx_ready_i),
    .ext_phy_sel_o(ext_phy_sel_o), .wake_en_o(wake_en_o), .force_col_o(force_col_o),
    .fdx_o(fdx_o), .loop_mode_o(loop_mode_o), .soft_rst_o(soft_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic wk, input logic [1:0] tx);
    wake_event_i = wk; tx_done_i = tx;
    @(negedge clk);
    wake_event_i = 1'b0; tx_done_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 ctl outputs", {ext_phy_sel_o, wake_en_o, force_col_o, fdx_o, loop_mode_o, soft_rst_o}, 0);
    rd(4'h0, d); chk("R1 ctl read", d, 8'h00);
    rd(4'h1, d); chk("R1 status read", d, 8'h00);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] d;
    wr(4'h0, 8'h80);
    wr(4'h0, 8'hDE);
    rd(4'h0, d); chk("R2 ctl readback", d, 8'hDE);
    chk("R2 outputs", {ext_phy_sel_o, wake_en_o, force_col_o, fdx_o, loop_mode_o}, 6'b111111);
    wr(4'h0, 8'hE4);
    rd(4'h0, d); chk("R2 bit5 reads 0", d, 8'hC4);
    chk("R2 loop mode PHY digital", loop_mode_o, 2);
    wr(4'h0, 8'h82);
    chk("R2 loop mode MAC", loop_mode_o, 1);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_duplex();
    logic [7:0] d;
    phy_fdx_i = 1'b1;
    wr(4'h0, 8'h08);
    rd(4'h0, d); chk("R3 internal reflects phy", d, 8'h08);
    phy_fdx_i = 1'b0;
    #1 chk("R3 internal fdx_o follows phy", fdx_o, 0);
    rd(4'h0, d); chk("R3 internal write ignored", d, 8'h00);
    wr(4'h0, 8'h80);
    wr(4'h0, 8'h88);
    phy_fdx_i = 1'b0;
    rd(4'h0, d); chk("R3 external stored", d, 8'h88);
    chk("R3 external fdx_o", fdx_o, 1);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_status_live();
    logic [7:0] d;
    phy_speed10_i = 1; phy_link_i = 1; tx_count_i = 2; rx_overflow_i = 1; rx_ready_i = 1;
    rd(4'h1, d); chk("R6 live all", d, 8'hD3);
    phy_speed10_i = 0; tx_count_i = 1; rx_overflow_i = 0;
    rd(4'h1, d); chk("R6 tx count 1 not full", d, 8'h41);
    tx_count_i = 3;
    rd(4'h1, d); chk("R6 tx count 3 full", d, 8'h51);
    phy_link_i = 0; tx_count_i = 0; rx_ready_i = 0;
  endtask

  task automatic t_flags();
    logic [7:0] d;
    pulse(1'b1, 2'b00);
    rd(4'h1, d); chk("R7 wake ignored when disabled", d, 8'h00);
    wr(4'h0, 8'h40);
    pulse(1'b1, 2'b00); pulse(1'b0, 2'b01); pulse(1'b0, 2'b10);
    repeat (3) @(negedge clk);
    rd(4'h1, d); chk("R7 flags set and held", d, 8'h2C);
    rd(4'h1, d); chk("R8 cleared by read", d, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    pulse(1'b1, 2'b11);
    wr(4'h1, 8'h04);
    rd(4'h1, d); chk("R9 only tx1 cleared", d, 8'h28);
    pulse(1'b1, 2'b11);
    wr(4'h1, 8'hD3);
    rd(4'h1, d); chk("R9 zeros and other bits no effect", d, 8'h2C);
    pulse(1'b1, 2'b11);
    wr(4'h1, 8'h28);
    rd(4'h1, d); chk("R9 wake and tx2 cleared", d, 8'h04);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    bus_addr = 4'h1; bus_rd = 1'b1; tx_done_i = 2'b01;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; tx_done_i = '0;
    chk("R10 read shows old value", d, 8'h00);
    rd(4'h1, d); chk("R10 set beats read clear", d, 8'h04);
    pulse(1'b0, 2'b10);
    bus_addr = 4'h1; bus_wdata = 8'h08; bus_wr = 1'b1; tx_done_i = 2'b10;
    @(negedge clk);
    bus_wr = 1'b0; tx_done_i = '0;
    rd(4'h1, d); chk("R10 set beats write-one clear", d, 8'h08);
  endtask

  task automatic t_wake_dis();
    logic [7:0] d;
    pulse(1'b1, 2'b00);
    wr(4'h0, 8'h00);
    chk("R11 wake enable off", wake_en_o, 0);
    rd(4'h1, d); chk("R11 wake flag cleared", d, 8'h00);
  endtask

  task automatic t_srst();
    logic [7:0] d;
    int n;
    wr(4'h0, 8'hC0);
    wr(4'h0, 8'hDE);
    pulse(1'b1, 2'b01);
    wr(4'h0, 8'hDF);               // starts soft reset
    n = 1;                          // sampled high at this edge
    chk("R4 soft reset asserted", soft_rst_o, 1);
    wr(4'h0, 8'hDF); n++;           // ignored restart, fields held
    rd(4'h0, d); n++;
    chk("R5 ctl during reset", d, 8'hC1);
    pulse(1'b0, 2'b11); n++;        // lost during reset
    rd(4'h1, d); n++;
    chk("R5 wake kept tx cleared", d, 8'h20);
    while (soft_rst_o && n < 4 * NSRST) begin
      @(negedge clk); n++;
    end
    chk("R4 soft reset length", n - 1, NSRST);
    rd(4'h0, d); chk("R4 R5 ctl after reset", d, 8'hC0);
    chk("R5 outputs after reset", {ext_phy_sel_o, wake_en_o, force_col_o, loop_mode_o}, 5'b11000);
    rd(4'h1, d); chk("R5 tx pulse during reset lost", d, 8'h00);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(4'h0, 8'h12);
    wr(4'h5, 8'hFF);
    rd(4'h0, d); chk("R12 write elsewhere no effect", d, 8'h12);
    rd(4'h5, d); chk("R12 unmapped read", d, 8'h00);
    chk("R12 no soft reset", soft_rst_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_duplex();
    t_status_live();
    t_flags();
    t_w1c();
    t_prio();
    t_wake_dis();
    t_srst();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule